// File: doc/BRIEF.md
# Frame-Averaged Automatic Brightness Controller

This block sits in a streaming video path and keeps picture brightness inside a programmable window without software in the loop. RGB pixels arrive with a frame-start pulse, a line-active level and a pixel-valid strobe. For every counted pixel it forms a cheap intensity estimate from shifts and adds and sums these estimates across the frame. The frame size is a power of two, so the mean comes from a plain bit-slice of the sum.

When the next frame-start arrives, the mean of the frame just closed is reported. It is then compared with a lower and an upper threshold, and a brightness gain moves one step toward the window. That gain scales all three colour components of every pixel from that frame-start onward. The correction always trails the measurement by one frame, so the loop settles over several frames rather than in one.

The scaled stream leaves with the same strobe timing as the input, two clocks later. Each scaled component saturates at full scale.

Top module: `bright_ctl`

## Requirements
- R1: A pixel's intensity is (R>>2)+(G>>1)+(B>>2) on 8-bit components, an 8-bit result built from shifts and adds only.
- R2: On each frame-start after the first one since reset, `meanLevel` takes the accumulated intensity sum of the closed frame shifted right by PIX_LOG2. `meanValid` is high for exactly the one cycle after that frame-start cycle.
- R3: The intensity accumulator saturates at all ones instead of wrapping, so an oversize bright frame reports a mean of 255.
- R4: The first frame-start after reset closes no frame: it produces no `meanValid` and leaves the gain unchanged, whatever pixels came before it.
- R5: A mean strictly below `lowThr` raises the gain by one LSB (1/16).
- R6: A mean strictly above `highThr` lowers the gain by one LSB.
- R7: A mean inside the window, both thresholds included, leaves the gain unchanged.
- R8: The gain is unsigned 4.4 fixed point. It resets to 1.0 (16) and never leaves the range 0.25 (4) to 4.0 (64).
- R9: Each output component equals min(255, floor(component*gain/16)).
- R10: `outFrameStart`, `outLineValid` and `outPixValid` repeat the matching inputs exactly two clocks later. Each output pixel is the input pixel from two clocks earlier.
- R11: A gain decided at a frame-start applies to that frame-start cycle and to every later pixel. Pixels before it keep the previous gain.
- R12: Only cycles with both `inLineValid` and `inPixValid` high add to the intensity sum. A pixel-valid cycle outside an active line still passes through scaled, but does not change the mean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowThr | input | 8 | Lower bound of the target mean window |
| highThr | input | 8 | Upper bound of the target mean window |
| inFrameStart | input | 1 | One-cycle pulse that closes the running frame and opens the next |
| inLineValid | input | 1 | High while a line is active |
| inPixValid | input | 1 | Pixel strobe |
| inR | input | 8 | Red component in |
| inG | input | 8 | Green component in |
| inB | input | 8 | Blue component in |
| outFrameStart | output | 1 | Frame-start delayed two clocks |
| outLineValid | output | 1 | Line-active delayed two clocks |
| outPixValid | output | 1 | Pixel strobe delayed two clocks |
| outR | output | 8 | Scaled red component |
| outG | output | 8 | Scaled green component |
| outB | output | 8 | Scaled blue component |
| meanLevel | output | 8 | Mean intensity of the last closed frame |
| meanValid | output | 1 | One-cycle pulse marking a fresh `meanLevel` |

## Verification
The bench drives long runs of dark frames and of bright frames, pushing the gain into both clamps. A design that wraps the gain would then flip brightness abruptly. A design that clamps at the wrong bound would scale pixels wrongly at 4.0 or at 0.25, where full-scale inputs must saturate and must not fold back to small values. An oversize frame of bright pixels checks that the sum saturates and does not report a tiny mean. Pixel-valid cycles outside active lines check that stray strobes leave the mean unchanged. The partial frame before the first frame-start and the first pixels after each frame-start catch a gain that updates one frame early, one frame late, or from garbage after reset.

// File: rtl/bright_pkg.sv
package bright_pkg;
  // Strobes from control to datapath for the current input cycle.
  typedef struct packed {
    logic frameEdge;  // frame-start seen on the input this cycle
    logic pixTake;    // pixel counts toward the frame sum
  } ctlStrobe_t;
endpackage

// File: rtl/bright_gainmul.sv
module bright_gainmul #(
  parameter int COMP_W    = 8,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4
) (
  input  logic [COMP_W-1:0] comp,
  input  logic [GAIN_W-1:0] gain,
  output logic [COMP_W-1:0] res
);
  localparam int PROD_W = COMP_W + GAIN_W;
  localparam int GAIN_ONE = 1 << GAIN_FRAC;

  logic [GAIN_W-1:0][PROD_W-1:0] part;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;

  // One shifted copy of the component per set gain bit.
  for (genvar g = 0; g < GAIN_W; g++) begin : g_part
    assign part[g] = gain[g] ? (PROD_W'(comp) << g) : '0;
  end

  always_comb begin
    prod = '0;
    for (int g = 0; g < GAIN_W; g++) prod = prod + part[g];
  end

  assign scaled = prod >> GAIN_FRAC;
  assign res = (|scaled[PROD_W-1:COMP_W]) ? '1 : scaled[COMP_W-1:0];

  // A gain of unity or above never makes a component darker.
  always_comb begin
    if (gain >= GAIN_W'(GAIN_ONE)) begin
      AST_NO_SHRINK: assert (res >= comp); // R9
    end
  end
endmodule

// File: rtl/bright_datapath.sv
module bright_datapath
  import bright_pkg::*;
#(
  parameter int PIX_LOG2  = 4,
  parameter int COMP_W    = 8,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  localparam int ACC_W    = PIX_LOG2 + COMP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              inFrameStart,
  input  logic              inLineValid,
  input  logic              inPixValid,
  input  logic [COMP_W-1:0] inR,
  input  logic [COMP_W-1:0] inG,
  input  logic [COMP_W-1:0] inB,
  input  logic [GAIN_W-1:0] gain,
  output logic [ACC_W-1:0]  accSum,
  output logic              outFrameStart,
  output logic              outLineValid,
  output logic              outPixValid,
  output logic [COMP_W-1:0] outR,
  output logic [COMP_W-1:0] outG,
  output logic [COMP_W-1:0] outB
);
  localparam int NCOMP = 3;

  // Shift-add intensity estimate.
  logic [COMP_W-1:0] pixInten;
  assign pixInten = (inR >> 2) + (inG >> 1) + (inB >> 2);

  // Saturating frame accumulator.
  logic [ACC_W-1:0] accReg;
  logic [ACC_W:0]   accNext;
  logic [ACC_W-1:0] intenExt;
  assign intenExt = {{(ACC_W-COMP_W){1'b0}}, pixInten};
  assign accNext  = {1'b0, accReg} + {1'b0, intenExt};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
    end else if (strobe.frameEdge) begin
      accReg <= strobe.pixTake ? intenExt : '0;
    end else if (strobe.pixTake) begin
      accReg <= accNext[ACC_W] ? '1 : accNext[ACC_W-1:0];
    end
  end
  assign accSum = accReg;

  // Stage 1: register the incoming pixel and strobes.
  logic [NCOMP-1:0][COMP_W-1:0] s1Comp;
  logic [NCOMP-1:0][COMP_W-1:0] mulRes;
  logic s1Fs, s1Lv, s1Pv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Comp <= '0;
      s1Fs   <= 1'b0;
      s1Lv   <= 1'b0;
      s1Pv   <= 1'b0;
    end else begin
      s1Comp <= {inB, inG, inR};
      s1Fs   <= inFrameStart;
      s1Lv   <= inLineValid;
      s1Pv   <= inPixValid;
    end
  end

  // Stage 2: scale by the gain that is current one cycle after capture.
  for (genvar c = 0; c < NCOMP; c++) begin : g_mul
    bright_gainmul #(
      .COMP_W   (COMP_W),
      .GAIN_W   (GAIN_W),
      .GAIN_FRAC(GAIN_FRAC)
    ) u_mul (
      .comp(s1Comp[c]),
      .gain(gain),
      .res (mulRes[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outR          <= '0;
      outG          <= '0;
      outB          <= '0;
      outFrameStart <= 1'b0;
      outLineValid  <= 1'b0;
      outPixValid   <= 1'b0;
    end else begin
      outR          <= mulRes[0];
      outG          <= mulRes[1];
      outB          <= mulRes[2];
      outFrameStart <= s1Fs;
      outLineValid  <= s1Lv;
      outPixValid   <= s1Pv;
    end
  end

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pixTake && !strobe.frameEdge) |=> (accSum >= $past(accSum))); // R3

  AST_IDLE_HOLDS_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pixTake && !strobe.frameEdge) |=> $stable(accSum)); // R12

  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |=> (outPixValid == $past(inPixValid, 2))); // R10
endmodule

// File: rtl/bright_control.sv
module bright_control
  import bright_pkg::*;
#(
  parameter int PIX_LOG2  = 4,
  parameter int COMP_W    = 8,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  parameter int GAIN_MIN  = 4,
  parameter int GAIN_MAX  = 64,
  localparam int ACC_W    = PIX_LOG2 + COMP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inFrameStart,
  input  logic              inLineValid,
  input  logic              inPixValid,
  input  logic [COMP_W-1:0] lowThr,
  input  logic [COMP_W-1:0] highThr,
  input  logic [ACC_W-1:0]  accSum,
  output ctlStrobe_t        strobe,
  output logic [GAIN_W-1:0] gain,
  output logic [COMP_W-1:0] meanLevel,
  output logic              meanValid
);
  localparam int GAIN_ONE = 1 << GAIN_FRAC;

  logic seenStart;
  logic [COMP_W-1:0] frameMean;
  logic isLow, isHigh;

  assign strobe.frameEdge = inFrameStart;
  assign strobe.pixTake   = inLineValid & inPixValid;

  // Power-of-two frame: the mean is the top bits of the sum.
  assign frameMean = accSum[ACC_W-1 -: COMP_W];
  assign isLow     = frameMean < lowThr;
  assign isHigh    = frameMean > highThr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gain      <= GAIN_W'(GAIN_ONE);
      seenStart <= 1'b0;
      meanLevel <= '0;
      meanValid <= 1'b0;
    end else begin
      meanValid <= 1'b0;
      if (strobe.frameEdge) begin
        seenStart <= 1'b1;
        if (seenStart) begin
          meanLevel <= frameMean;
          meanValid <= 1'b1;
          if (isLow && gain < GAIN_W'(GAIN_MAX)) begin
            gain <= gain + 1'b1;
          end else if (isHigh && gain > GAIN_W'(GAIN_MIN)) begin
            gain <= gain - 1'b1;
          end
        end
      end
    end
  end

  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (gain >= GAIN_W'(GAIN_MIN)) && (gain <= GAIN_W'(GAIN_MAX))); // R8

  AST_GAIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.frameEdge && seenStart) |=> $stable(gain)); // R4

  AST_GAIN_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameEdge && seenStart && isLow && gain != GAIN_W'(GAIN_MAX))
      |=> (gain == $past(gain) + 1'b1)); // R5

  AST_GAIN_LOWER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameEdge && seenStart && isHigh && !isLow && gain != GAIN_W'(GAIN_MIN))
      |=> (gain == $past(gain) - 1'b1)); // R6

  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameEdge && !isLow && !isHigh) |=> $stable(gain)); // R7

  AST_MEAN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    meanValid |=> !meanValid); // R2
endmodule

// File: rtl/bright_ctl.sv
module bright_ctl
  import bright_pkg::*;
#(
  parameter int PIX_LOG2  = 4,
  parameter int COMP_W    = 8,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  parameter int GAIN_MIN  = 4,
  parameter int GAIN_MAX  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [COMP_W-1:0] lowThr,
  input  logic [COMP_W-1:0] highThr,
  input  logic              inFrameStart,
  input  logic              inLineValid,
  input  logic              inPixValid,
  input  logic [COMP_W-1:0] inR,
  input  logic [COMP_W-1:0] inG,
  input  logic [COMP_W-1:0] inB,
  output logic              outFrameStart,
  output logic              outLineValid,
  output logic              outPixValid,
  output logic [COMP_W-1:0] outR,
  output logic [COMP_W-1:0] outG,
  output logic [COMP_W-1:0] outB,
  output logic [COMP_W-1:0] meanLevel,
  output logic              meanValid
);
  localparam int ACC_W = PIX_LOG2 + COMP_W;

  ctlStrobe_t        strobe;
  logic [GAIN_W-1:0] gain;
  logic [ACC_W-1:0]  accSum;

  bright_control #(
    .PIX_LOG2(PIX_LOG2), .COMP_W(COMP_W), .GAIN_W(GAIN_W),
    .GAIN_FRAC(GAIN_FRAC), .GAIN_MIN(GAIN_MIN), .GAIN_MAX(GAIN_MAX)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .inFrameStart(inFrameStart), .inLineValid(inLineValid), .inPixValid(inPixValid),
    .lowThr(lowThr), .highThr(highThr), .accSum(accSum),
    .strobe(strobe), .gain(gain), .meanLevel(meanLevel), .meanValid(meanValid)
  );

  bright_datapath #(
    .PIX_LOG2(PIX_LOG2), .COMP_W(COMP_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inFrameStart(inFrameStart), .inLineValid(inLineValid), .inPixValid(inPixValid),
    .inR(inR), .inG(inG), .inB(inB), .gain(gain), .accSum(accSum),
    .outFrameStart(outFrameStart), .outLineValid(outLineValid), .outPixValid(outPixValid),
    .outR(outR), .outG(outG), .outB(outB)
  );
endmodule

// File: tb/sim_bright_ctl.sv
`timescale 1ns/1ps
module sim_bright_ctl;
  localparam int N = 4;
  localparam int ACC_MAX = (1 << (N + 8)) - 1;
  localparam int LOW = 100;
  localparam int HIGH = 140;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] lowThr = 8'(LOW);
  logic [7:0] highThr = 8'(HIGH);
  logic inFrameStart = 0, inLineValid = 0, inPixValid = 0;
  logic [7:0] inR = 0, inG = 0, inB = 0;
  logic outFrameStart, outLineValid, outPixValid;
  logic [7:0] outR, outG, outB, meanLevel;
  logic meanValid;

  always #5 clk = ~clk;

  bright_ctl u0 (
    .clk(clk), .rstN(rstN), .lowThr(lowThr), .highThr(highThr),
    .inFrameStart(inFrameStart), .inLineValid(inLineValid), .inPixValid(inPixValid),
    .inR(inR), .inG(inG), .inB(inB),
    .outFrameStart(outFrameStart), .outLineValid(outLineValid), .outPixValid(outPixValid),
    .outR(outR), .outG(outG), .outB(outB), .meanLevel(meanLevel), .meanValid(meanValid)
  );

  typedef struct {
    bit fs, lv, pv;
    int r, g, b;
    string tag;
  } item_t;

  item_t pixQ[$];
  int meanQ[$];
  string meanTagQ[$];
  int checks = 0, errors = 0;
  int accM = 0, gainM = 16;
  bit seenM = 0;
  bit done = 0;

  function automatic int scale(input int c, input int g);
    int v = (c * g) >> 4;
    return (v > 255) ? 255 : v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of input, updates the model, pushes expectations.
  task automatic cyc(input bit fs, input bit lv, input bit pv,
                     input int r, input int g, input int b, input string tag);
    item_t it;
    bit take;
    int inten, mean;
    @(negedge clk);
    inFrameStart = fs; inLineValid = lv; inPixValid = pv;
    inR = 8'(r); inG = 8'(g); inB = 8'(b);
    take = lv && pv;
    inten = (r >> 2) + (g >> 1) + (b >> 2);
    if (fs) begin
      if (seenM) begin
        mean = accM >> N;
        meanQ.push_back(mean);
        meanTagQ.push_back(tag);
        if (mean < LOW && gainM < 64) gainM++;
        else if (mean > HIGH && gainM > 4) gainM--;
      end
      seenM = 1;
      accM = take ? inten : 0;
    end else if (take) begin
      accM = accM + inten;
      if (accM > ACC_MAX) accM = ACC_MAX;
    end
    it.fs = fs; it.lv = lv; it.pv = pv;
    it.r = scale(r, gainM); it.g = scale(g, gainM); it.b = scale(b, gainM);
    it.tag = tag;
    pixQ.push_back(it);
  endtask

  // Monitor: compares each output cycle against the oldest expectation.
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (pixQ.size() >= 2) begin
        it = pixQ.pop_front();
        check({it.tag, " R10 strobes"}, {outFrameStart, outLineValid, outPixValid},
              {it.fs, it.lv, it.pv});
        if (it.pv) begin
          check({it.tag, " R9 R11 red"}, outR, it.r);
          check({it.tag, " R9 R11 green"}, outG, it.g);
          check({it.tag, " R9 R11 blue"}, outB, it.b);
        end
      end
      if (meanValid) begin
        if (meanQ.size() == 0) begin
          check("R4 unexpected meanValid", 1, 0);
        end else begin
          check({meanTagQ.pop_front(), " R1 R2 mean"}, meanLevel, meanQ.pop_front());
        end
      end
    end
  end

  task automatic frame(input int n, input int base, input int step,
                       input bit gaps, input string tag);
    cyc(1, 0, 0, 0, 0, 0, tag);
    for (int i = 0; i < n; i++) begin
      int v = (base + i * step) & 255;
      if (gaps && (i % 5 == 4)) cyc(0, 1, 0, 9, 9, 9, tag);
      if (gaps && (i % 8 == 7)) cyc(0, 0, 0, 0, 0, 0, tag);
      cyc(0, 1, 1, v, (v + 17) & 255, v ^ 8'h5a, tag);
    end
  endtask

  task automatic flat(input int n, input int v, input string tag);
    cyc(1, 0, 0, 0, 0, 0, tag);
    for (int i = 0; i < n; i++) cyc(0, 1, 1, v, v, v, tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state.
    check("R8 reset outPixValid", outPixValid, 0);
    check("R2 reset meanValid", meanValid, 0);
    check("R2 reset meanLevel", meanLevel, 0);
    check("R10 reset outR", outR, 0);
    rstN = 1'b1;

    // Partial frame before any frame-start: counted but never judged.
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 250, 250, 250, "R4 partial");
    flat(16, 40, "R4 first");                 // closes nothing
    for (int k = 0; k < 3; k++) flat(16, 40, "R5 dark");
    for (int k = 0; k < 3; k++) flat(16, 250, "R6 bright");
    for (int k = 0; k < 2; k++) flat(16, 120, "R7 window");
    flat(16, 100, "R7 lower edge");           // intensity 100 sits on lowThr
    flat(16, 140, "R7 upper edge");
    frame(16, 3, 16, 1, "R1 ramp");
    frame(16, 200, 7, 1, "R12 gaps");
    // Stray pixel strobes outside a line must not count.
    cyc(1, 0, 0, 0, 0, 0, "R12 stray");
    for (int i = 0; i < 16; i++) begin
      cyc(0, 1, 1, 120, 120, 120, "R12 stray");
      cyc(0, 0, 1, 255, 255, 255, "R12 stray");
    end
    for (int k = 0; k < 60; k++) flat(16, 30, "R8 clamp high");
    frame(16, 200, 3, 0, "R9 saturate");
    flat(300, 250, "R3 oversize");
    for (int k = 0; k < 70; k++) flat(16, 250, "R8 clamp low");
    frame(16, 250, 1, 0, "R8 at floor");
    cyc(1, 0, 0, 0, 0, 0, "R2 close");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, "R10 idle");
    repeat (3) @(negedge clk);
    check("R2 pending means drained", meanQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule